// File: doc/BRIEF.md
# Start-up and Power-Good Sequencer

This block is the digital control for a core-voltage regulator's power-up and power-good handling. Once the supply is valid and the enable input is high, it holds the regulator at a boot level while a slow ramp brings the output up. It then waits for the output to be in regulation and for the neighbouring supplies to report good on the shared power-good line. At that moment it captures the voltage-identification (VID) code. After a short fixed delay it directs the reference to the VID target, or to a sleep setpoint, with the fast ramp source switched on.

A power-good timer counts switching cycles from the capture onwards. The open-drain power-good pull-down is released only after that timer expires, while the output sits inside its regulation window and no fault is latched. Later changes of the VID code in active mode are taken once they have been steady for two clocks. Every VID or mode change blanks the window check until the analog ramp reports done, plus one further switching cycle. Ramp generation and the DAC itself live outside this block. The block only selects among them and times them.

Top module: `pgoodSequencer`

## Requirements
- R1: The sequence leaves its reset state only on a clock edge where supplyOk and enable are both high. Whenever either one is low at a clock edge, the block returns to reset after that edge: targetSel=0, boostEn=0, pullDown=1 and vidLatched=0.
- R2: During soft-start and while holding at the boot level, targetSel is 0 (boot) and boostEn is 0.
- R3: vidLatched captures vidIn only at the first clock edge, after the ramp-done flag has been seen at the boot level, on which inWindow and extGoodIn are both high. vidIn changes before that edge leave vidLatched unchanged. Bit 0 of the code is the least significant bit and is carried through unchanged.
- R4: CAP_DLY_CLK clocks after the capture edge, boostEn rises and targetSel switches from boot to the mode target.
- R5: pullDown stays 1 until PG_DELAY_CYC swTick pulses have been counted after the capture edge. The pulse on the capture edge itself is not counted. It may go to 0 only after the edge that counts the last of these pulses.
- R6: Mode decode once past the delay: deeperSleep=1 gives targetSel=3 whatever the value of deepSleepN; deeperSleep=0 with deepSleepN=0 gives targetSel=2; deeperSleep=0 with deepSleepN=1 (active) gives targetSel=1, the VID target.
- R7: After start-up, in active mode only, a new vidIn value is latched at the second consecutive clock edge on which it is sampled unchanged. A value present for a single edge is ignored. VID changes in either sleep mode are ignored.
- R8: A VID relatch or a mode change starts a mask. While the mask is active, an out-of-window output does not pull power-good low. The mask ends at the first swTick edge after rampDone has been sampled high.
- R9: pullDown is 1 whenever faultLatch is 1, and whenever inWindow is 0 and no mask is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| supplyOk | input | 1 | Supply above its reset threshold (hysteresis applied outside) |
| enable | input | 1 | Regulator enable |
| swTick | input | 1 | One-clock pulse per switching cycle |
| extGoodIn | input | 1 | Sensed external power-good from the other supplies |
| rampDone | input | 1 | Analog reference ramp has reached its target |
| inWindow | input | 1 | Output voltage inside the regulation window |
| faultLatch | input | 1 | A protection fault is latched |
| deepSleepN | input | 1 | Low requests deep sleep |
| deeperSleep | input | 1 | High requests deeper sleep |
| vidIn | input | VID_W | VID code, bit 0 least significant |
| targetSel | output | 2 | Reference select: 0 boot, 1 VID, 2 deep, 3 deeper |
| vidLatched | output | VID_W | Captured VID code |
| boostEn | output | 1 | Enables the additional ramp current source |
| pullDown | output | 1 | Drives the open-drain power-good low |

## Verification
The hardest state to reach is the edge of the power-good release. It needs the whole start-up chain completed, and then the exact swTick count after capture. The bench produces swTick from its own divider and counts every pulse from the capture edge onwards. This lets it sample pullDown one pulse before the timer limit and again on the limit. The mask is exercised by dropping inWindow together with rampDone while a relatch or mode change is in progress. The mask must hold until rampDone returns and a switching pulse follows.

// File: rtl/seqPkg.sv
package seqPkg;

  typedef enum logic [2:0] {
    ST_RESET,
    ST_SOFT,
    ST_HOLD,
    ST_DELAY,
    ST_RAMP,
    ST_RUN
  } seqState_t;

  typedef struct packed {
    logic clearAll;
    logic captureVid;
    logic runMode;
  } seqStrobe_t;

  localparam logic [1:0] TGT_BOOT   = 2'd0;
  localparam logic [1:0] TGT_VID    = 2'd1;
  localparam logic [1:0] TGT_DEEP   = 2'd2;
  localparam logic [1:0] TGT_DEEPER = 2'd3;

  localparam logic [1:0] MODE_ACTIVE = 2'd0;
  localparam logic [1:0] MODE_DEEP   = 2'd1;
  localparam logic [1:0] MODE_DEEPER = 2'd2;

endpackage

// File: rtl/seqCtrl.sv
module seqCtrl
  import seqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyOk,
  input  logic       enable,
  input  logic       rampDone,
  input  logic       inWindow,
  input  logic       extGoodIn,
  input  logic       faultLatch,
  input  logic       deepSleepN,
  input  logic       deeperSleep,
  input  logic       delayDone,
  input  logic       pgTimerDone,
  input  logic       maskActive,
  output seqStrobe_t strobe,
  output logic [1:0] modeNow,
  output logic [1:0] targetSel,
  output logic       boostEn,
  output logic       pullDown
);

  seqState_t state, stateNext;
  logic goOn;
  logic extReady;

  assign goOn     = supplyOk && enable;
  assign extReady = inWindow && extGoodIn;

  always_comb begin
    if (deeperSleep)      modeNow = MODE_DEEPER;
    else if (!deepSleepN) modeNow = MODE_DEEP;
    else                  modeNow = MODE_ACTIVE;
  end

  always_comb begin
    stateNext = state;
    if (!goOn) begin
      stateNext = ST_RESET;
    end else begin
      unique case (state)
        ST_RESET: stateNext = ST_SOFT;
        ST_SOFT:  if (rampDone)    stateNext = ST_HOLD;
        ST_HOLD:  if (extReady)    stateNext = ST_DELAY;
        ST_DELAY: if (delayDone)   stateNext = ST_RAMP;
        ST_RAMP:  if (rampDone)    stateNext = ST_RUN;
        ST_RUN:   stateNext = ST_RUN;
        default:  stateNext = ST_RESET;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RESET;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.clearAll   = !goOn;
    strobe.captureVid = goOn && (state == ST_HOLD) && extReady;
    strobe.runMode    = goOn && (state == ST_RUN);
  end

  always_comb begin
    boostEn   = (state == ST_RAMP) || (state == ST_RUN);
    targetSel = TGT_BOOT;
    if (boostEn) begin
      unique case (modeNow)
        MODE_DEEP:   targetSel = TGT_DEEP;
        MODE_DEEPER: targetSel = TGT_DEEPER;
        default:     targetSel = TGT_VID;
      endcase
    end
    pullDown = faultLatch ||
               !((state == ST_RUN) && pgTimerDone && (inWindow || maskActive));
  end

endmodule

// File: rtl/seqDatapath.sv
module seqDatapath
  import seqPkg::*;
#(
  parameter int VID_W        = 6,
  parameter int CAP_DLY_CLK  = 100,
  parameter int PG_DELAY_CYC = 3072
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic             swTick,
  input  logic             rampDone,
  input  logic [1:0]       modeNow,
  input  logic [VID_W-1:0] vidIn,
  output logic [VID_W-1:0] vidLatched,
  output logic             delayDone,
  output logic             pgTimerDone,
  output logic             maskActive
);

  localparam int DLY_W = $clog2(CAP_DLY_CLK + 1);
  localparam int PG_W  = $clog2(PG_DELAY_CYC + 1);
  localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(CAP_DLY_CLK - 1);
  localparam logic [PG_W-1:0]  PG_LAST  = PG_W'(PG_DELAY_CYC);

  localparam logic [1:0] MSK_IDLE = 2'd0;
  localparam logic [1:0] MSK_RAMP = 2'd1;
  localparam logic [1:0] MSK_TICK = 2'd2;

  logic [VID_W-1:0] vidPrev;
  logic [1:0]       modePrev;
  logic [DLY_W-1:0] dlyCnt;
  logic [PG_W-1:0]  pgCnt;
  logic             pgRun;
  logic [1:0]       maskPhase;
  logic             relatch;
  logic             maskStart;

  assign relatch   = strobe.runMode && (modeNow == MODE_ACTIVE) &&
                     (vidIn == vidPrev) && (vidIn != vidLatched);
  assign maskStart = strobe.runMode && (relatch || (modeNow != modePrev));

  // sampling of the raw inputs for stability and change detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vidPrev  <= '0;
      modePrev <= MODE_ACTIVE;
    end else begin
      vidPrev  <= vidIn;
      modePrev <= modeNow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  vidLatched <= '0;
    else if (strobe.clearAll)   vidLatched <= '0;
    else if (strobe.captureVid) vidLatched <= vidIn;
    else if (relatch)           vidLatched <= vidIn;
  end

  // delay between capture and the ramp to target
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    dlyCnt <= '0;
    else if (strobe.clearAll)     dlyCnt <= '0;
    else if (strobe.captureVid)   dlyCnt <= '0;
    else if (dlyCnt != DLY_LAST)  dlyCnt <= dlyCnt + 1'b1;
  end
  assign delayDone = (dlyCnt == DLY_LAST);

  // power-good timer in switching cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pgCnt <= '0;
      pgRun <= 1'b0;
    end else if (strobe.clearAll) begin
      pgCnt <= '0;
      pgRun <= 1'b0;
    end else if (strobe.captureVid) begin
      pgCnt <= '0;
      pgRun <= 1'b1;
    end else if (pgRun && swTick && (pgCnt != PG_LAST)) begin
      pgCnt <= pgCnt + 1'b1;
    end
  end
  assign pgTimerDone = pgRun && (pgCnt == PG_LAST);

  // transition blanking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                maskPhase <= MSK_IDLE;
    else if (strobe.clearAll) maskPhase <= MSK_IDLE;
    else if (maskStart)       maskPhase <= MSK_RAMP;
    else begin
      unique case (maskPhase)
        MSK_RAMP: if (rampDone) maskPhase <= MSK_TICK;
        MSK_TICK: if (swTick)   maskPhase <= MSK_IDLE;
        default:  maskPhase <= MSK_IDLE;
      endcase
    end
  end
  assign maskActive = (maskPhase != MSK_IDLE);

endmodule

// File: rtl/pgoodSequencer.sv
module pgoodSequencer
  import seqPkg::*;
#(
  parameter int VID_W        = 6,
  parameter int CAP_DLY_CLK  = 100,
  parameter int PG_DELAY_CYC = 3072
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             supplyOk,
  input  logic             enable,
  input  logic             swTick,
  input  logic             extGoodIn,
  input  logic             rampDone,
  input  logic             inWindow,
  input  logic             faultLatch,
  input  logic             deepSleepN,
  input  logic             deeperSleep,
  input  logic [VID_W-1:0] vidIn,
  output logic [1:0]       targetSel,
  output logic [VID_W-1:0] vidLatched,
  output logic             boostEn,
  output logic             pullDown
);

  seqStrobe_t strobe;
  logic [1:0] modeNow;
  logic       delayDone;
  logic       pgTimerDone;
  logic       maskActive;

  seqCtrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .supplyOk    (supplyOk),
    .enable      (enable),
    .rampDone    (rampDone),
    .inWindow    (inWindow),
    .extGoodIn   (extGoodIn),
    .faultLatch  (faultLatch),
    .deepSleepN  (deepSleepN),
    .deeperSleep (deeperSleep),
    .delayDone   (delayDone),
    .pgTimerDone (pgTimerDone),
    .maskActive  (maskActive),
    .strobe      (strobe),
    .modeNow     (modeNow),
    .targetSel   (targetSel),
    .boostEn     (boostEn),
    .pullDown    (pullDown)
  );

  seqDatapath #(
    .VID_W        (VID_W),
    .CAP_DLY_CLK  (CAP_DLY_CLK),
    .PG_DELAY_CYC (PG_DELAY_CYC)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .swTick      (swTick),
    .rampDone    (rampDone),
    .modeNow     (modeNow),
    .vidIn       (vidIn),
    .vidLatched  (vidLatched),
    .delayDone   (delayDone),
    .pgTimerDone (pgTimerDone),
    .maskActive  (maskActive)
  );

endmodule

// File: rtl/pgoodSequencerChk.sv
module pgoodSequencerChk #(
  parameter int VID_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             supplyOk,
  input logic             enable,
  input logic             faultLatch,
  input logic [VID_W-1:0] vidIn,
  input logic [1:0]       targetSel,
  input logic [VID_W-1:0] vidLatched,
  input logic             boostEn,
  input logic             pullDown
);

  a_r1_drop_resets: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> (!boostEn && pullDown && targetSel == 2'd0 && vidLatched == '0));

  a_r9_fault_pulls: assert property (@(posedge clk) disable iff (!rstN)
    faultLatch |-> pullDown);

  a_r3_latch_source: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(vidLatched) && $past(supplyOk && enable)) |-> vidLatched == $past(vidIn));

  a_r4_boost_keeps_vid: assert property (@(posedge clk) disable iff (!rstN)
    $rose(boostEn) |-> $stable(vidLatched));

  a_r5_release_running: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pullDown) |-> (boostEn && !faultLatch));

endmodule

bind pgoodSequencer pgoodSequencerChk #(.VID_W(VID_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .supplyOk   (supplyOk),
  .enable     (enable),
  .faultLatch (faultLatch),
  .vidIn      (vidIn),
  .targetSel  (targetSel),
  .vidLatched (vidLatched),
  .boostEn    (boostEn),
  .pullDown   (pullDown)
);

// File: tb/pgoodSequencer_tb.sv
`timescale 1ns/1ps
module pgoodSequencer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int VID_W = 6;
  localparam int CAP_DLY = 100;
  localparam int PG_DLY = 3072;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyOk = 1'b0, enable = 1'b0, swTick = 1'b0, extGoodIn = 1'b0;
  logic rampDone = 1'b0, inWindow = 1'b0, faultLatch = 1'b0;
  logic deepSleepN = 1'b1, deeperSleep = 1'b0;
  logic [VID_W-1:0] vidIn = '0;
  logic [1:0] targetSel;
  logic [VID_W-1:0] vidLatched;
  logic boostEn, pullDown;

  int checks = 0;
  int fails = 0;
  int tickTotal = 0;
  int tickBase = 0;
  logic [1:0] divCnt = 2'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    divCnt <= divCnt + 2'd1;
    swTick <= (divCnt == 2'd3);
  end

  always @(posedge clk) if (swTick) tickTotal <= tickTotal + 1;

  pgoodSequencer #(.VID_W(VID_W), .CAP_DLY_CLK(CAP_DLY), .PG_DELAY_CYC(PG_DLY)) dut_i (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .enable(enable), .swTick(swTick),
    .extGoodIn(extGoodIn), .rampDone(rampDone), .inWindow(inWindow),
    .faultLatch(faultLatch), .deepSleepN(deepSleepN), .deeperSleep(deeperSleep),
    .vidIn(vidIn), .targetSel(targetSel), .vidLatched(vidLatched),
    .boostEn(boostEn), .pullDown(pullDown)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tReset;
    @(negedge clk);
    chk(targetSel == 2'd0, "R1 reset targetSel", targetSel, 0);
    chk(boostEn == 1'b0, "R1 reset boostEn", boostEn, 0);
    chk(pullDown == 1'b1, "R1 reset pullDown", pullDown, 1);
    chk(vidLatched == '0, "R1 reset vidLatched", vidLatched, 0);
    rstN = 1'b1;
    clocks(2);
  endtask

  task automatic tNoStartWithoutEnable;
    supplyOk = 1'b1; enable = 1'b0;
    rampDone = 1'b1; inWindow = 1'b1; extGoodIn = 1'b1; vidIn = 6'h05;
    clocks(10);
    chk(vidLatched == '0, "R1 no start without enable", vidLatched, 0);
    chk(boostEn == 1'b0, "R1 boost off without enable", boostEn, 0);
    rampDone = 1'b0; inWindow = 1'b0; extGoodIn = 1'b0;
  endtask

  task automatic tStartup;
    enable = 1'b1;
    clocks(3);
    chk(targetSel == 2'd0, "R2 soft-start target boot", targetSel, 0);
    chk(boostEn == 1'b0, "R2 soft-start boost off", boostEn, 0);
    vidIn = 6'h12; rampDone = 1'b1;
    clocks(3);
    inWindow = 1'b1;
    clocks(5);
    chk(vidLatched == '0, "R3 no capture without external good", vidLatched, 0);
    chk(boostEn == 1'b0, "R2 hold boost off", boostEn, 0);
    vidIn = 6'h15; extGoodIn = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(vidLatched == 6'h15, "R3 capture on external good", vidLatched, 6'h15);
    tickBase = tickTotal;
    rampDone = 1'b0;
    clocks(CAP_DLY - 1);
    chk(boostEn == 1'b0, "R4 boost off before delay end", boostEn, 0);
    chk(targetSel == 2'd0, "R4 target boot before delay end", targetSel, 0);
    clocks(1);
    chk(boostEn == 1'b1, "R4 boost on after delay", boostEn, 1);
    chk(targetSel == 2'd1, "R4 target VID after delay", targetSel, 1);
    rampDone = 1'b1;
    clocks(3);
    chk(pullDown == 1'b1, "R5 pullDown held before timer", pullDown, 1);
    while (tickTotal - tickBase < PG_DLY - 1) @(negedge clk);
    chk(pullDown == 1'b1, "R5 pullDown one tick before limit", pullDown, 1);
    while (tickTotal - tickBase < PG_DLY) @(negedge clk);
    chk(pullDown == 1'b0, "R5 pullDown released at limit", pullDown, 0);
  endtask

  task automatic tVidRelatch;
    vidIn = 6'h16; rampDone = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(vidLatched == 6'h15, "R7 no relatch after one edge", vidLatched, 6'h15);
    @(posedge clk); @(negedge clk);
    chk(vidLatched == 6'h16, "R7 relatch after two edges", vidLatched, 6'h16);
    inWindow = 1'b0;
    clocks(20);
    chk(pullDown == 1'b0, "R8 mask holds while ramp busy", pullDown, 0);
    rampDone = 1'b1;
    clocks(8);
    chk(pullDown == 1'b1, "R8 mask ends after ramp done and tick", pullDown, 1);
    inWindow = 1'b1;
    #1;
    chk(pullDown == 1'b0, "R9 back in window releases", pullDown, 0);
  endtask

  task automatic tGlitch;
    @(negedge clk);
    vidIn = 6'h30;
    @(posedge clk); @(negedge clk);
    vidIn = 6'h16;
    clocks(4);
    chk(vidLatched == 6'h16, "R7 single-edge glitch ignored", vidLatched, 6'h16);
  endtask

  task automatic tFault;
    faultLatch = 1'b1;
    #1;
    chk(pullDown == 1'b1, "R9 fault pulls low", pullDown, 1);
    @(negedge clk);
    faultLatch = 1'b0;
    #1;
    chk(pullDown == 1'b0, "R9 fault cleared releases", pullDown, 0);
  endtask

  task automatic tModes;
    @(negedge clk);
    deepSleepN = 1'b0; rampDone = 1'b0;
    #1;
    chk(targetSel == 2'd2, "R6 deep sleep target", targetSel, 2);
    @(negedge clk);
    inWindow = 1'b0;
    vidIn = 6'h01;
    clocks(10);
    chk(pullDown == 1'b0, "R8 mode change masks window", pullDown, 0);
    chk(vidLatched == 6'h16, "R7 VID ignored in deep sleep", vidLatched, 6'h16);
    rampDone = 1'b1; inWindow = 1'b1;
    clocks(10);
    deeperSleep = 1'b1;
    #1;
    chk(targetSel == 2'd3, "R6 deeper sleep target", targetSel, 3);
    deepSleepN = 1'b1;
    #1;
    chk(targetSel == 2'd3, "R6 deeper with deepSleepN high", targetSel, 3);
    vidIn = 6'h16;
    clocks(10);
    deeperSleep = 1'b0;
    #1;
    chk(targetSel == 2'd1, "R6 back to active VID target", targetSel, 1);
    clocks(10);
    inWindow = 1'b0;
    #1;
    chk(pullDown == 1'b1, "R9 unmasked out-of-window pulls low", pullDown, 1);
    @(negedge clk);
    inWindow = 1'b1;
  endtask

  task automatic tSupplyDrop;
    @(negedge clk);
    supplyOk = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(targetSel == 2'd0, "R1 supply drop target", targetSel, 0);
    chk(boostEn == 1'b0, "R1 supply drop boost", boostEn, 0);
    chk(pullDown == 1'b1, "R1 supply drop pullDown", pullDown, 1);
    chk(vidLatched == '0, "R1 supply drop vidLatched", vidLatched, 0);
  endtask

  initial begin
    clocks(3);
    tReset();
    tNoStartWithoutEnable();
    tStartup();
    tVidRelatch();
    tGlitch();
    tFault();
    tModes();
    tSupplyDrop();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule